// File: doc/BRIEF.md
# Triple-Source Response Voting Evaluator

This block sits at the receiving end of a run-time self-test in which three identical cores are fed the same stimulus and send their response words back. Nothing golden is stored: the three responses judge each other. Each core's words reach the block on their own valid/ready stream. The rates are independent and can change over time, so one stream may deliver twice as fast as the others. Every stream lands in a small private FIFO. Words are matched purely by arrival order, because each stream is delivered in order.

As soon as all three FIFOs hold a word, the oldest word of each is removed in the same cycle. The three words are voted bit by bit, and the per-source disagreement with the voted word is reported. A source whose FIFO fills has its ready dropped, which throttles a fast source until the slower ones catch up. Under the single-fault assumption, a comparison in which exactly one source disagrees charges that source: its sticky fault bit is set and its saturating mismatch counter is incremented. When two or more sources disagree in the same word, no single faulty core explains the result. A sticky ambiguity flag is raised instead, and no source is charged. A synchronous clear empties the FIFOs and zeroes every flag and counter before a new session.

Top module: `tri_vote_eval`

## Requirements
- R1: After reset, and in the cycle after a one-cycle `clear`, all FIFOs are empty, `vote_valid` is 0, `fault_sticky` and `ambig_flag` are 0 and every mismatch counter is 0.
- R2: Source i (i = 0, 1, 2) owns bit i of `in_valid`/`in_ready` and bits `[i*WORD_W +: WORD_W]` of `in_data`. A word is taken on a rising edge where both `in_valid[i]` and `in_ready[i]` are 1. `in_ready[i]` is 1 exactly when FIFO i holds fewer than `FIFO_DEPTH` words and `clear` is 0.
- R3: A comparison happens only when all three FIFOs are non-empty, and it removes exactly one word from each. A source that is ahead keeps its extra words buffered and produces no output.
- R4: The k-th word accepted from each source is compared with the k-th word of the other two.
- R5: A comparison whose words were all buffered before edge E gives a one-cycle `vote_valid` after edge E+1. `vote_word` holds the bitwise majority of the three words.
- R6: While `vote_valid` is 1, bit i of `fault_now` is 1 exactly when source i's word differs from `vote_word`. Otherwise `fault_now` is 0.
- R7: A comparison with two or more bits of `fault_now` set sets `ambig_flag`, which stays set until `clear`. It changes no fault bit and no counter.
- R8: A comparison with exactly one bit of `fault_now` set sets that source's bit in `fault_sticky`, which stays set until `clear`. It also adds one to that source's counter, which saturates at 2^CNT_W - 1.
- R9: The counter of source i is `mismatch_cnt[i*CNT_W +: CNT_W]`.
- R10: During `clear`, all `in_ready` bits are 0. Words already buffered are discarded, so a later comparison uses only words accepted after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous session clear |
| in_valid | input | 3 | Per-source word valid |
| in_data | input | 3*WORD_W | Per-source response words, source i at slice i |
| in_ready | output | 3 | Per-source ready (back-pressure) |
| vote_valid | output | 1 | One-cycle pulse per comparison |
| vote_word | output | WORD_W | Bitwise majority of the compared words |
| fault_now | output | 3 | Per-source disagreement for the current comparison |
| fault_sticky | output | 3 | Per-source sticky fault bits |
| ambig_flag | output | 1 | Sticky flag for comparisons with no single-fault explanation |
| mismatch_cnt | output | 3*CNT_W | Per-source saturating mismatch counters |

## Verification
The bench builds the block with 8-bit words, a FIFO depth of 4 and 3-bit counters. With depth 4, one source can be run until it is full and back-pressured within a handful of pushes while the other two stay empty; the order of its buffered words is then checked as they drain. With 3-bit counters, saturation at 7 is reached after a few mismatching comparisons. The 8-bit words keep the hand-worked majority vectors short, including vectors in which two sources disagree at different bit positions.

// File: rtl/tve_pkg.sv
package tve_pkg;
    localparam int NSRC = 3;

    // bitwise two-out-of-three
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/tve_fifo.sv
module tve_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t fst_d, fst_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        fst_d = fst_q;
        if (clear) begin
            fst_d.wr  = '0;
            fst_d.rd  = '0;
            fst_d.cnt = '0;
        end else begin
            if (push) begin
                fst_d.mem[fst_q.wr] = push_data;
                fst_d.wr            = ptr_next(fst_q.wr);
            end
            if (pop) begin
                fst_d.rd = ptr_next(fst_q.rd);
            end
            fst_d.cnt = fst_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fst_q <= '0;
        else        fst_q <= fst_d;
    end

    assign head     = fst_q.mem[fst_q.rd];
    assign nonempty = (fst_q.cnt != '0);
    assign full     = (fst_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/tve_voter.sv
module tve_voter
    import tve_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    input  logic [W-1:0] word_c,
    output logic [W-1:0] majority,
    output logic [2:0]   differs
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign majority[b] = maj3(word_a[b], word_b[b], word_c[b]);
    end

    assign differs[0] = (word_a != majority);
    assign differs[1] = (word_b != majority);
    assign differs[2] = (word_c != majority);
endmodule

// File: rtl/tri_vote_eval.sv
module tri_vote_eval
    import tve_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [2:0]            in_valid,
    input  logic [3*WORD_W-1:0]   in_data,
    output logic [2:0]            in_ready,
    output logic                  vote_valid,
    output logic [WORD_W-1:0]     vote_word,
    output logic [2:0]            fault_now,
    output logic [2:0]            fault_sticky,
    output logic                  ambig_flag,
    output logic [3*CNT_W-1:0]    mismatch_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic                         vld;
        logic [WORD_W-1:0]            word;
        logic [NSRC-1:0]              flt_now;
        logic [NSRC-1:0]              sticky;
        logic                         ambig;
        logic [NSRC-1:0][CNT_W-1:0]   cnt;
    } eval_st_t;

    eval_st_t ev_d, ev_q;

    logic [NSRC-1:0]             src_nonempty;
    logic [NSRC-1:0]             src_full;
    logic [NSRC-1:0][WORD_W-1:0] src_head;
    logic                        pop_all;
    logic [WORD_W-1:0]           maj_word;
    logic [NSRC-1:0]             diff_mask;

    assign pop_all = (&src_nonempty) & ~clear;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign in_ready[s] = ~src_full[s] & ~clear;

        tve_fifo #(
            .W     (WORD_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear),
            .push      (in_valid[s] & in_ready[s]),
            .push_data (in_data[s*WORD_W +: WORD_W]),
            .pop       (pop_all),
            .head      (src_head[s]),
            .nonempty  (src_nonempty[s]),
            .full      (src_full[s])
        );
    end

    tve_voter #(
        .W (WORD_W)
    ) u_voter (
        .word_a   (src_head[0]),
        .word_b   (src_head[1]),
        .word_c   (src_head[2]),
        .majority (maj_word),
        .differs  (diff_mask)
    );

    always_comb begin
        ev_d         = ev_q;
        ev_d.vld     = 1'b0;
        ev_d.flt_now = '0;
        if (clear) begin
            ev_d = '0;
        end else if (pop_all) begin
            ev_d.vld     = 1'b1;
            ev_d.word    = maj_word;
            ev_d.flt_now = diff_mask;
            if ($countones(diff_mask) > 1) begin
                ev_d.ambig = 1'b1;
            end else begin
                for (int s = 0; s < NSRC; s++) begin
                    if (diff_mask[s]) begin
                        ev_d.sticky[s] = 1'b1;
                        if (ev_q.cnt[s] != CNT_MAX) begin
                            ev_d.cnt[s] = ev_q.cnt[s] + CNT_W'(1);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign vote_valid   = ev_q.vld;
    assign vote_word    = ev_q.word;
    assign fault_now    = ev_q.flt_now;
    assign fault_sticky = ev_q.sticky;
    assign ambig_flag   = ev_q.ambig;
    assign mismatch_cnt = ev_q.cnt;
endmodule

// File: rtl/tve_checker.sv
module tve_checker #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear,
    input logic [2:0]         in_ready,
    input logic [2:0]         src_nonempty,
    input logic               vote_valid,
    input logic [2:0]         fault_now,
    input logic [2:0]         fault_sticky,
    input logic               ambig_flag,
    input logic [3*CNT_W-1:0] mismatch_cnt
);
    a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!vote_valid && fault_sticky == '0 && !ambig_flag && mismatch_cnt == '0));

    a_r10_ready_low_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (in_ready == 3'b000));

    a_r3_vote_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        vote_valid |-> ($past(src_nonempty) == 3'b111 && !$past(clear)));

    a_r6_quiet_without_vote: assert property (@(posedge clk) disable iff (!rst_n)
        !vote_valid |-> (fault_now == 3'b000));

    a_r7_ambig_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_valid && $countones(fault_now) > 1) |-> ambig_flag);

    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((fault_sticky & $past(fault_sticky)) == $past(fault_sticky)));

    a_r8_count_on_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mismatch_cnt) && !$past(clear)) |-> (vote_valid && $countones(fault_now) == 1));
endmodule

bind tri_vote_eval tve_checker #(
    .CNT_W (CNT_W)
) u_tve_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .in_ready     (in_ready),
    .src_nonempty (src_nonempty),
    .vote_valid   (vote_valid),
    .fault_now    (fault_now),
    .fault_sticky (fault_sticky),
    .ambig_flag   (ambig_flag),
    .mismatch_cnt (mismatch_cnt)
);

// File: tb/tb_tri_vote_eval.sv
module tb_tri_vote_eval;
    localparam int W  = 8;
    localparam int D  = 4;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clear = 1'b0;
    logic [2:0]      in_valid = 3'b000;
    logic [3*W-1:0]  in_data = '0;
    logic [2:0]      in_ready;
    logic            vote_valid;
    logic [W-1:0]    vote_word;
    logic [2:0]      fault_now;
    logic [2:0]      fault_sticky;
    logic            ambig_flag;
    logic [3*CW-1:0] mismatch_cnt;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    int      m_cnt [3];
    logic [2:0] m_sticky;
    logic    m_ambig;

    always #10 clk = ~clk;

    tri_vote_eval #(.WORD_W(W), .FIFO_DEPTH(D), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .vote_valid(vote_valid),
        .vote_word(vote_word), .fault_now(fault_now), .fault_sticky(fault_sticky),
        .ambig_flag(ambig_flag), .mismatch_cnt(mismatch_cnt)
    );

    // {src0, src1, src2, expected vote, expected disagreement mask (bit i = source i)}
    localparam logic [34:0] VEC [8] = '{
        {8'h3C, 8'h3C, 8'h3C, 8'h3C, 3'b000},
        {8'h3C, 8'h3D, 8'h3C, 8'h3C, 3'b010},
        {8'hA5, 8'hA5, 8'h25, 8'hA5, 3'b100},
        {8'h0F, 8'hF0, 8'h0F, 8'h0F, 3'b010},
        {8'h01, 8'h02, 8'h00, 8'h00, 3'b011},
        {8'hFF, 8'h00, 8'h00, 8'h00, 3'b001},
        {8'h55, 8'hAA, 8'hFF, 8'hFF, 3'b011},
        {8'h00, 8'h00, 8'h80, 8'h00, 3'b100}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive the selected sources for one cycle, then wait for the registered result
    task automatic push(input logic [2:0] m, input logic [W-1:0] w0, input logic [W-1:0] w1, input logic [W-1:0] w2);
        @(negedge clk);
        in_valid = m;
        in_data  = {w2, w1, w0};
        @(negedge clk);
        in_valid = 3'b000;
        @(negedge clk);
    endtask

    task automatic model_update(input logic [2:0] m);
        if ($countones(m) > 1) m_ambig = 1'b1;
        else begin
            for (int s = 0; s < 3; s++) begin
                if (m[s]) begin
                    m_sticky[s] = 1'b1;
                    if (m_cnt[s] < 7) m_cnt[s]++;
                end
            end
        end
    endtask

    task automatic check_state(input string req);
        for (int s = 0; s < 3; s++)
            chk(mismatch_cnt[s*CW +: CW] == CW'(m_cnt[s]), req, 32'(mismatch_cnt[s*CW +: CW]), 32'(m_cnt[s]));
        chk(fault_sticky == m_sticky, req, 32'(fault_sticky), 32'(m_sticky));
        chk(ambig_flag == m_ambig, req, 32'(ambig_flag), 32'(m_ambig));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int acc;
        m_cnt = '{0, 0, 0};
        m_sticky = 3'b000;
        m_ambig = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(vote_valid == 1'b0, "R1 vote_valid after reset", 32'(vote_valid), 0);
        chk(in_ready == 3'b111, "R2 ready after reset", 32'(in_ready), 32'h7);
        check_state("R1 reset state");

        // table walk: R5 majority, R6 mask, R7 ambiguity, R8 counting
        for (int v = 0; v < 8; v++) begin
            push(3'b111, VEC[v][34:27], VEC[v][26:19], VEC[v][18:11]);
            chk(vote_valid == 1'b1, "R5 vote_valid", 32'(vote_valid), 1);
            chk(vote_word == VEC[v][10:3], "R5 majority word", 32'(vote_word), 32'(VEC[v][10:3]));
            chk(fault_now == VEC[v][2:0], "R6 fault mask", 32'(fault_now), 32'(VEC[v][2:0]));
            model_update(VEC[v][2:0]);
            check_state("R7 R8 R9 sticky/counters");
            @(negedge clk);
            chk(vote_valid == 1'b0, "R5 single-cycle pulse", 32'(vote_valid), 0);
        end

        // R1 R10: clear discards a buffered word
        push(3'b001, 8'h77, 8'h00, 8'h00);
        chk(vote_valid == 1'b0, "R3 no vote with one source", 32'(vote_valid), 0);
        @(negedge clk);
        clear = 1'b1;
        #1;
        chk(in_ready == 3'b000, "R10 ready low in clear", 32'(in_ready), 0);
        @(negedge clk);
        clear = 1'b0;
        m_cnt = '{0, 0, 0};
        m_sticky = 3'b000;
        m_ambig = 1'b0;
        check_state("R1 after clear");
        chk(vote_valid == 1'b0, "R1 vote_valid after clear", 32'(vote_valid), 0);
        push(3'b110, 8'h00, 8'h33, 8'h33);
        chk(vote_valid == 1'b0, "R10 stale word discarded", 32'(vote_valid), 0);
        push(3'b001, 8'h33, 8'h00, 8'h00);
        chk(vote_valid == 1'b1, "R10 fresh compare", 32'(vote_valid), 1);
        chk(vote_word == 8'h33, "R10 fresh word", 32'(vote_word), 32'h33);
        chk(fault_now == 3'b000, "R10 no stale mismatch", 32'(fault_now), 0);

        // R2 R3: run source 2 ahead until full
        acc = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid[2] = 1'b1;
            in_data[2*W +: W] = W'(8'h10 + acc);
            if (in_ready[2]) acc++;
            chk(vote_valid == 1'b0, "R3 no vote while behind", 32'(vote_valid), 0);
        end
        chk(acc == D, "R2 accepted up to depth", 32'(acc), D);
        chk(in_ready[2] == 1'b0, "R2 back-pressure when full", 32'(in_ready[2]), 0);
        chk(in_ready[1:0] == 2'b11, "R2 other sources ready", 32'(in_ready[1:0]), 3);
        @(negedge clk);
        in_valid = 3'b000;

        // R4 drain in order
        for (int k = 0; k < 4; k++) begin
            push(3'b011, W'(8'h10 + k), W'(8'h10 + k), 8'h00);
            chk(vote_valid == 1'b1, "R4 aligned compare", 32'(vote_valid), 1);
            chk(vote_word == W'(8'h10 + k), "R4 order", 32'(vote_word), 32'(8'h10 + k));
            chk(fault_now == 3'b000, "R4 matched position", 32'(fault_now), 0);
            if (k == 0) chk(in_ready[2] == 1'b1, "R2 ready after pop", 32'(in_ready[2]), 1);
        end

        // R8 R9 saturation of source 1 counter
        for (int k = 0; k < 9; k++) begin
            push(3'b111, 8'h5A, 8'hA5, 8'h5A);
            model_update(3'b010);
            chk(fault_now == 3'b010, "R6 source1 flagged", 32'(fault_now), 2);
            check_state("R8 saturating counter");
        end
        chk(mismatch_cnt[1*CW +: CW] == 3'd7, "R9 counter at max", 32'(mismatch_cnt[1*CW +: CW]), 7);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule